// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector

This block gathers the event pulses raised by an I2C bus engine into sticky status flags, lets a host enable each flag through a mask register, and reports the most urgent enabled, pending event as a three-bit code in a vector register. One interrupt line goes high while any enabled flag is set. A host takes the interrupt, reads the vector to learn which event happened, and acts on it. Each read of the vector clears the flag it reports, so reading it repeatedly walks through every pending event until it reads zero.

Besides the seven sticky flags, the status register also shows two live, read-only levels from the bus engine: bus busy and receive shift register full. Access is through a plain 16-bit register port with a request, a write enable and a two-bit word address. Reads return data combinationally in the request cycle. Writes and clear-on-read side effects take effect at the next clock edge.

Top module: `i2c_evt_vector`

## Requirements
- R1: Each event pulse on `evt_i` sets a sticky flag that shows in the status register (address 0) at the same bit as its `evt_i` index: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R2: The vector register (address 2) reads the code of the pending enabled source with the lowest bit index, that index plus one: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed as slave 7. The code is placed in bits 2:0.
- R3: The vector register reads 0 when no enabled flag is set.
- R4: Writing 1 to status bit 2 (access ready) or bit 5 (stop detected) clears that flag. Writing to any other status bit leaves the flags unchanged.
- R5: Status bit 12 shows `bus_busy_i` and bit 11 shows `rx_shift_full_i` live in the read cycle. Both are read-only. The other unused status bits read 0.
- R6: Only flags whose mask bit (mask register, address 1, bits 6:0 in the status bit order) is 1 contribute to the vector and to `irq_o`. Flags whose mask bit is 0 are still recorded in the status register.
- R7: A read of the vector register that returns a nonzero code clears the flag of the source it reported, from the next cycle on.
- R8: `irq_o` is high exactly when some flag is set and its mask bit is 1. It rises in the cycle after the edge that captures an enabled event pulse.
- R9: When an event pulse arrives in the same cycle as a clear of its own flag, by status write or by vector read, the flag stays set.
- R10: The mask register holds bits 6:0 as written; bits 15:7 read 0. Address 3 reads 0.
- R11: After reset all flags and all mask bits are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | One-cycle event pulses from the bus engine, indexed by status bit |
| bus_busy_i | input | 1 | Bus busy level |
| rx_shift_full_i | input | 1 | Receive shift register full level |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Word address: 0 status, 1 mask, 2 vector |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the request cycle |
| irq_o | output | 1 | Interrupt request, high while an enabled flag is set |

## Verification
Read data is combinational. It reflects the register state before the edge that ends the request cycle, so the bench samples it one time unit after driving the request, mid-cycle. An event pulse or a clear becomes visible in status, vector and `irq_o` only in the cycle after the next rising edge. The bench's behavioural model therefore applies each cycle's stimulus to its own state at that edge and compares `irq_o` and any read data against the state from before it. Same-cycle collisions between a pulse and a clear of its own flag, masked sources, and a vector walk through several pending events are each driven in their own cycle.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned NUM_EVT  = 7;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned CODE_W   = $clog2(NUM_EVT + 1);
  localparam int unsigned BUSY_BIT = 12;
  localparam int unsigned RSF_BIT  = 11;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR = 2'd2;

  // flags the host may clear by writing one: access ready, stop detected
  localparam logic [NUM_EVT-1:0] W1C_BITS = 7'b010_0100;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flags_o[g] <= 1'b0;
      else if (set_i[g])    flags_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])    flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int unsigned N  = 7,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    code_o   = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o   = CW'(i + 1);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import i2c_evt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EVT-1:0] flags_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NUM_EVT-1:0] win_i,
  input  logic               bus_busy_i,
  input  logic               rx_shift_full_i,
  output logic [NUM_EVT-1:0] mask_o,
  output logic [NUM_EVT-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic wr_st, wr_mask, rd_vec;

  assign wr_st   = req_i &  we_i & (addr_i == ADDR_STATUS);
  assign wr_mask = req_i &  we_i & (addr_i == ADDR_MASK);
  assign rd_vec  = req_i & ~we_i & (addr_i == ADDR_VECTOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_o <= '0;
    else if (wr_mask) mask_o <= wdata_i[NUM_EVT-1:0];
  end

  always_comb begin
    clr_o = '0;
    if (wr_st)  clr_o = clr_o | (wdata_i[NUM_EVT-1:0] & W1C_BITS);
    if (rd_vec) clr_o = clr_o | win_i;
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        ADDR_STATUS: begin
          rdata_o[NUM_EVT-1:0] = flags_i;
          rdata_o[BUSY_BIT]    = bus_busy_i;
          rdata_o[RSF_BIT]     = rx_shift_full_i;
        end
        ADDR_MASK:   rdata_o[NUM_EVT-1:0] = mask_o;
        ADDR_VECTOR: rdata_o[CODE_W-1:0]  = code_i;
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_evt_vector.sv
module i2c_evt_vector
  import i2c_evt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_busy_i,
  input  logic               rx_shift_full_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flags_q, mask_q, clr, pend, win;
  logic [CODE_W-1:0]  code;

  evt_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_i),
    .clr_i   (clr),
    .flags_o (flags_q)
  );

  assign pend = flags_q & mask_q;

  evt_prio_enc #(.N(NUM_EVT), .CW(CODE_W)) u_prio (
    .req_i    (pend),
    .code_o   (code),
    .onehot_o (win)
  );

  evt_reg_port u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_i           (req_i),
    .we_i            (we_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .flags_i         (flags_q),
    .code_i          (code),
    .win_i           (win),
    .bus_busy_i      (bus_busy_i),
    .rx_shift_full_i (rx_shift_full_i),
    .mask_o          (mask_q),
    .clr_o           (clr),
    .rdata_o         (rdata_o)
  );

  assign irq_o = |pend;
endmodule

// File: rtl/i2c_evt_vector_chk.sv
module i2c_evt_vector_chk
  import i2c_evt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               bus_busy_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] flags_q,
  input logic [NUM_EVT-1:0] mask_q
);
  logic vec_rd, st_rd;
  logic [NUM_EVT-1:0] rd_oh;

  assign vec_rd = req_i && !we_i && (addr_i == ADDR_VECTOR);
  assign st_rd  = req_i && !we_i && (addr_i == ADDR_STATUS);

  always_comb begin
    rd_oh = '0;
    if (rdata_o[CODE_W-1:0] != '0) rd_oh[rdata_o[CODE_W-1:0] - 1'b1] = 1'b1;
  end

  assert_irq_after_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(evt_i & mask_q)) && !(req_i && we_i)) |=> irq_o);

  assert_vec_zero_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd |-> ((rdata_o != '0) == irq_o));

  assert_vec_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd |-> (rdata_o[DATA_W-1:CODE_W] == '0));

  assert_vec_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && (rdata_o != '0) && ((evt_i & rd_oh) == '0)) |=> ((flags_q & $past(rd_oh)) == '0));

  assert_evt_sticks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  assert_busy_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd |-> (rdata_o[BUSY_BIT] == bus_busy_i && rdata_o[15:13] == 3'b0 && rdata_o[10:7] == 4'b0));
endmodule

bind i2c_evt_vector i2c_evt_vector_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .bus_busy_i (bus_busy_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .flags_q    (flags_q),
  .mask_q     (mask_q)
);

// File: tb/i2c_evt_vector_tb_top.sv
module i2c_evt_vector_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  evt_i = '0;
  logic        bus_busy_i = 1'b0;
  logic        rx_shift_full_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit [6:0] m_flags = '0;
  bit [6:0] m_mask  = '0;

  always #2 clk_i = ~clk_i;

  i2c_evt_vector dut_i (.*);

  function automatic int top_code();
    for (int i = 0; i < 7; i++) if (m_flags[i] && m_mask[i]) return i + 1;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, check mid-cycle, update model at posedge
  task automatic cyc(string tag, bit [6:0] ev, bit rq, bit wr, bit [1:0] ad, bit [15:0] wd);
    int exp_rd;
    int code;
    bit [6:0] clr;
    @(negedge clk_i);
    evt_i = ev; req_i = rq; we_i = wr; addr_i = ad; wdata_i = wd;
    #1;
    code = top_code();
    check("R8 irq", int'(irq_o), int'((m_flags & m_mask) != 0));
    if (rq && !wr) begin
      case (ad)
        2'd0: exp_rd = int'(m_flags) | (int'(bus_busy_i) << 12) | (int'(rx_shift_full_i) << 11);
        2'd1: exp_rd = int'(m_mask);
        2'd2: exp_rd = code;
        default: exp_rd = 0;
      endcase
      check(tag, int'(rdata_o), exp_rd);
    end
    clr = '0;
    if (rq && wr && ad == 2'd0) clr = wd[6:0] & 7'b010_0100;
    if (rq && !wr && ad == 2'd2 && code != 0) clr[code-1] = 1'b1;
    @(posedge clk_i);
    m_flags = ev | (m_flags & ~clr);
    if (rq && wr && ad == 2'd1) m_mask = wd[6:0];
  endtask

  task automatic rd(string tag, bit [1:0] ad);
    cyc(tag, '0, 1, 0, ad, '0);
  endtask

  task automatic wr(string tag, bit [1:0] ad, bit [15:0] wd);
    cyc(tag, '0, 1, 1, ad, wd);
  endtask

  task automatic pulse(string tag, bit [6:0] ev);
    cyc(tag, ev, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R11 reset state
    rd("R11 status", 2'd0);
    rd("R11 mask", 2'd1);
    rd("R11 vector", 2'd2);

    // R10 mask read/write
    wr("R10", 2'd1, 16'hFFFF);
    rd("R10 mask upper", 2'd1);
    rd("R10 addr3", 2'd3);
    wr("R10", 2'd1, 16'h0000);

    // R6 masked events recorded, no vector, no irq
    pulse("R6", 7'h7F);
    rd("R6 status", 2'd0);
    rd("R3 vector masked", 2'd2);
    wr("R10", 2'd1, 16'h007F);

    // R2/R7 walk through all pending
    for (int i = 0; i < 8; i++) rd("R7 walk", 2'd2);
    rd("R7 status empty", 2'd0);

    // R1/R2 each source alone
    for (int i = 0; i < 7; i++) begin
      pulse("R1", 7'(1 << i));
      rd("R1 status", 2'd0);
      rd("R2 vector", 2'd2);
      rd("R3 vector", 2'd2);
    end

    // R6 partial mask
    wr("R6", 2'd1, 16'h000A);
    pulse("R6", 7'h7F);
    rd("R6 vector", 2'd2);
    rd("R6 vector", 2'd2);
    rd("R3 vector", 2'd2);
    rd("R6 status", 2'd0);

    // R4 write-one-to-clear only on bits 2 and 5
    wr("R4", 2'd0, 16'hFFFF);
    rd("R4 status", 2'd0);
    wr("R4", 2'd0, 16'h0000);
    rd("R4 status", 2'd0);

    // R5 live read-only bits
    bus_busy_i = 1'b1;
    rd("R5 busy", 2'd0);
    rx_shift_full_i = 1'b1;
    bus_busy_i = 1'b0;
    wr("R5 write", 2'd0, 16'h1800);
    rd("R5 rsf", 2'd0);
    rx_shift_full_i = 1'b0;

    // R9 event beats clear
    wr("R9", 2'd1, 16'h007F);
    for (int i = 0; i < 8; i++) rd("R9 drain", 2'd2);
    pulse("R9", 7'h04);
    cyc("R9 w1c collide", 7'h04, 1, 1, 2'd0, 16'h0004);
    rd("R9 status", 2'd0);
    cyc("R9 vec collide", 7'h04, 1, 0, 2'd2, 16'h0);
    rd("R9 status", 2'd0);
    rd("R9 vector", 2'd2);
    rd("R9 vector", 2'd2);

    // R8 irq rises and falls with mask
    pulse("R8", 7'h40);
    wr("R8", 2'd1, 16'h0000);
    pulse("R8", 7'h00);
    wr("R8", 2'd1, 16'h0040);
    pulse("R8", 7'h00);
    rd("R8 vector", 2'd2);
    pulse("R8", 7'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule